// File: doc/BRIEF.md
# PCI Bus Parity Generator and Checker

This block produces and verifies the even parity bit that protects each address and data phase of a 32-bit PCI-style agent. Parity is taken over all thirty-two address/data lines together with the four command/byte-enable lines in every phase. Byte lanes or address bits that carry no meaningful value are still counted. When the agent drives a phase, the block presents the matching parity bit one clock later, with an output enable that lets the pad drive it. In every other cycle that enable is low, so the pad is released.

When the agent receives a phase, the block recomputes the parity of what it sampled and compares it with the parity bit seen on the following clock. Any mismatch sets a sticky detected-error status bit. The bit stays set until a write-one-to-clear strobe or reset clears it. A response enable decides whether the block also reports the error on the bus. A data-phase error drives the active-low data error line for one clock. An address-phase error drives the active-low system error line for one clock instead.

The surrounding agent supplies the phase strobes and the role flag. It keeps the address strobe and the data strobe apart. If both are high in the same cycle, the phase counts as an address phase.

Top module: `pci_parity_unit`

## Requirements
- R1: After reset, `par_oe_o` and `parity_err_o` are 0, and `perr_n_o` and `serr_n_o` are 1.
- R2: When `drive_i`=1 and `addr_vld_i` or `data_vld_i` is high in cycle N, then in cycle N+1 `par_oe_o`=1 and `par_o` makes the number of ones across that phase's `ad_i[31:0]`, `cbe_i[3:0]` and `par_o` even.
- R3: In any cycle that does not follow a driven valid phase, `par_oe_o`=0.
- R4: When `drive_i`=0 and a phase is valid in cycle N, the block compares `par_i` in cycle N+1 with the even parity of that phase's `ad_i` and `cbe_i`. On a mismatch, `parity_err_o` is 1 from cycle N+2, whatever `resp_en_i` is.
- R5: `parity_err_o` stays 1 until `stat_clr_i`=1 in a cycle, after which it is 0 in the next cycle. A new error detected in that same cycle wins, and the bit stays 1.
- R6: On a received data-phase mismatch with `resp_en_i`=1 in cycle N+1, `perr_n_o` is 0 in cycle N+2 only, and `serr_n_o` stays 1.
- R7: On a received address-phase mismatch with `resp_en_i`=1 in cycle N+1, `serr_n_o` is 0 in cycle N+2 only, and `perr_n_o` stays 1.
- R8: When `resp_en_i`=0 in the compare cycle, a mismatch drives neither `perr_n_o` nor `serr_n_o` low.
- R9: Phases that the agent drives (`drive_i`=1) are never checked. A wrong `par_i` after them leaves `parity_err_o`, `perr_n_o` and `serr_n_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drive_i | input | 1 | 1: agent drives this phase; 0: agent receives it |
| addr_vld_i | input | 1 | Address phase valid this cycle |
| data_vld_i | input | 1 | Data phase valid this cycle |
| ad_i | input | 32 | Address/data lines as driven or sampled |
| cbe_i | input | 4 | Command/byte-enable lines as driven or sampled |
| par_i | input | 1 | Parity bit sampled from the bus |
| resp_en_i | input | 1 | Parity error response enable |
| stat_clr_i | input | 1 | Write-one-to-clear strobe for the status bit |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Drive enable for the parity pad |
| perr_n_o | output | 1 | Data parity error, active low |
| serr_n_o | output | 1 | Address parity error, active low |
| parity_err_o | output | 1 | Sticky detected-parity-error status |

## Verification
Directed phases use all-zero, all-ones and single-bit patterns on `ad_i` and `cbe_i`. These show that every one of the 36 lines feeds the parity, including the command/byte-enable lines. Received phases then alternate a correct parity bit with a flipped one, for both address and data phases and with the response enable on and off. This separates the status path from the two error lines and tells the address line from the data line. Driven phases with a deliberately wrong `par_i` show that the agent's own phases are never checked. A long random run mixes the role, the strobes, the enable and the clear strobe, including a clear in the same cycle as a new error.

// File: rtl/pci_par_pkg.sv
// Package: widths and phase record shared by the parity unit and its parts.
package pci_par_pkg;
    localparam int unsigned AD_W  = 32;
    localparam int unsigned CBE_W = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    // One registered phase: its kind, who drove it, and its computed parity.
    typedef struct packed {
        phase_e kind;
        logic   drv;
        logic   par;
    } phase_rec_t;
endpackage

// File: rtl/par_tree.sv
// Module: par_tree
// Computes the XOR of all W input bits (odd count -> 1).
// Assumes W >= 1; built as a generated chain so any width works.
module par_tree #(
    parameter int unsigned W = 36
) (
    input  logic [W-1:0] bits_i,
    output logic         odd_o
);
    logic [W:0] acc;

    assign acc[0] = 1'b0;
    for (genvar g = 0; g < W; g++) begin : g_chain
        // running XOR over bit g
        assign acc[g+1] = acc[g] ^ bits_i[g];
    end

    assign odd_o = acc[W];
endmodule

// File: rtl/phase_capture.sv
// Module: phase_capture
// Registers the kind, role and computed parity of the current bus phase so
// that the next cycle can drive or compare PAR. Address strobe wins if both
// strobes are high.
module phase_capture
    import pci_par_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       drive_i,
    input  logic       addr_vld_i,
    input  logic       data_vld_i,
    input  logic       odd_i,
    output phase_rec_t rec_q
);
    phase_e kind_d;

    // decode the phase kind, address first
    always_comb begin
        if (addr_vld_i)      kind_d = PH_ADDR;
        else if (data_vld_i) kind_d = PH_DATA;
        else                 kind_d = PH_IDLE;
    end

    // hold one cycle of phase history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q <= '{kind: PH_IDLE, drv: 1'b0, par: 1'b0};
        end else begin
            rec_q <= '{kind: kind_d, drv: drive_i, par: odd_i};
        end
    end
endmodule

// File: rtl/err_checker.sv
// Module: err_checker
// Compares the parity of a received phase (held in rec_i) with the PAR
// sampled one cycle later, keeps the sticky status bit and produces the
// one-clock active-low error strobes. Assumes rec_i is one cycle old.
module err_checker
    import pci_par_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  phase_rec_t rec_i,
    input  logic       par_i,
    input  logic       resp_en_i,
    input  logic       stat_clr_i,
    output logic       perr_n_o,
    output logic       serr_n_o,
    output logic       parity_err_o
);
    logic mismatch;
    logic perr_q, serr_q, stat_q;

    // a received valid phase whose PAR disagrees with the computed parity
    assign mismatch = (rec_i.kind != PH_IDLE) && !rec_i.drv && (rec_i.par != par_i);

    // error strobes, one clock, gated by the response enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr_q <= 1'b0;
            serr_q <= 1'b0;
        end else begin
            perr_q <= mismatch && resp_en_i && (rec_i.kind == PH_DATA);
            serr_q <= mismatch && resp_en_i && (rec_i.kind == PH_ADDR);
        end
    end

    // sticky status: set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n)          stat_q <= 1'b0;
        else if (mismatch)   stat_q <= 1'b1;
        else if (stat_clr_i) stat_q <= 1'b0;
    end

    assign perr_n_o     = ~perr_q;
    assign serr_n_o     = ~serr_q;
    assign parity_err_o = stat_q;
endmodule

// File: rtl/pci_parity_unit.sv
// Module: pci_parity_unit
// Even-parity generator and checker for a PCI-style agent. PAR for a driven
// phase appears one clock after it with the pad enable high; received phases
// are checked against PAR one clock later and errors reported one clock after
// that. Assumes the agent keeps the two phase strobes mutually exclusive.
module pci_parity_unit
    import pci_par_pkg::*;
#(
    parameter int unsigned AD_WIDTH  = AD_W,
    parameter int unsigned CBE_WIDTH = CBE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 drive_i,
    input  logic                 addr_vld_i,
    input  logic                 data_vld_i,
    input  logic [AD_WIDTH-1:0]  ad_i,
    input  logic [CBE_WIDTH-1:0] cbe_i,
    input  logic                 par_i,
    input  logic                 resp_en_i,
    input  logic                 stat_clr_i,
    output logic                 par_o,
    output logic                 par_oe_o,
    output logic                 perr_n_o,
    output logic                 serr_n_o,
    output logic                 parity_err_o
);
    localparam int unsigned LINES = AD_WIDTH + CBE_WIDTH;

    logic       odd;
    phase_rec_t rec_q;

    par_tree #(.W(LINES)) u_tree (
        .bits_i ({cbe_i, ad_i}),
        .odd_o  (odd)
    );

    phase_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .drive_i    (drive_i),
        .addr_vld_i (addr_vld_i),
        .data_vld_i (data_vld_i),
        .odd_i      (odd),
        .rec_q      (rec_q)
    );

    // drive PAR only in the cycle after a phase the agent drove
    assign par_oe_o = rec_q.drv && (rec_q.kind != PH_IDLE);
    assign par_o    = par_oe_o & rec_q.par;

    err_checker u_chk_logic (
        .clk          (clk),
        .rst_n        (rst_n),
        .rec_i        (rec_q),
        .par_i        (par_i),
        .resp_en_i    (resp_en_i),
        .stat_clr_i   (stat_clr_i),
        .perr_n_o     (perr_n_o),
        .serr_n_o     (serr_n_o),
        .parity_err_o (parity_err_o)
    );
endmodule

// File: rtl/pci_parity_unit_chk.sv
// Module: pci_parity_unit_chk
// Assertion checker bound to pci_parity_unit; observes ports only.
module pci_parity_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        drive_i,
    input logic        addr_vld_i,
    input logic        data_vld_i,
    input logic [31:0] ad_i,
    input logic [3:0]  cbe_i,
    input logic        par_i,
    input logic        resp_en_i,
    input logic        stat_clr_i,
    input logic        par_o,
    input logic        par_oe_o,
    input logic        perr_n_o,
    input logic        serr_n_o,
    input logic        parity_err_o
);
    // R2: driven phase gives enabled, even parity next cycle
    p_par_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_i && (addr_vld_i || data_vld_i)) |=>
            (par_oe_o && ((^{$past(ad_i), $past(cbe_i), par_o}) == 1'b0)));

    // R3: no drive enable without a driven phase the cycle before
    p_oe_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_i && (addr_vld_i || data_vld_i)) |=> !par_oe_o);

    // R4: every reported error line comes with the status bit
    p_status_with_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!perr_n_o || !serr_n_o) |-> parity_err_o);

    // R5: status holds without a clear strobe
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_err_o && !stat_clr_i) |=> parity_err_o);

    // R6/R7: the two error lines never fire together
    p_lines_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!perr_n_o && !serr_n_o));

    // R8: a reported line needs the enable in the compare cycle
    p_gated_by_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!perr_n_o || !serr_n_o) |-> $past(resp_en_i));
endmodule

bind pci_parity_unit pci_parity_unit_chk u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .drive_i      (drive_i),
    .addr_vld_i   (addr_vld_i),
    .data_vld_i   (data_vld_i),
    .ad_i         (ad_i),
    .cbe_i        (cbe_i),
    .par_i        (par_i),
    .resp_en_i    (resp_en_i),
    .stat_clr_i   (stat_clr_i),
    .par_o        (par_o),
    .par_oe_o     (par_oe_o),
    .perr_n_o     (perr_n_o),
    .serr_n_o     (serr_n_o),
    .parity_err_o (parity_err_o)
);

// File: tb/tb_pci_parity_unit.sv
// Bench for pci_parity_unit: directed corners then seeded random phases,
// compared each cycle against a cycle model built from the requirements.
module tb_pci_parity_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        drive_i = 1'b0, addr_vld_i = 1'b0, data_vld_i = 1'b0;
    logic [31:0] ad_i = '0;
    logic [3:0]  cbe_i = '0;
    logic        par_i = 1'b0, resp_en_i = 1'b0, stat_clr_i = 1'b0;
    logic        par_o, par_oe_o, perr_n_o, serr_n_o, parity_err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pci_parity_unit dut (.*);

    // model history: the previous cycle's phase
    bit          p_vld = 0, p_drv = 0, p_addr = 0;
    logic [35:0] p_bits = '0;
    // pending compare outcome (settled at the edge just taken)
    bit          e_cond = 0, e_addr = 0, e_en = 0;
    bit          e_drvbad = 0;
    bit          exp_stat = 0;

    function automatic logic even_par(input logic [35:0] b);
        return ^b;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // check outputs for the current cycle, then apply this cycle's inputs
    task automatic step(input bit drv, input bit av, input bit dv,
                        input logic [31:0] ad, input logic [3:0] cbe,
                        input bit bad, input bit en, input bit clr);
        bit exp_oe, exp_perr, exp_serr, cond;
        string lt;
        @(negedge clk);
        exp_oe = p_vld && p_drv;
        chk(exp_oe ? "R2" : "R3", par_oe_o, exp_oe, "par_oe_o");
        if (exp_oe) chk("R2", par_o, even_par(p_bits), "par_o");
        exp_perr = !(e_cond && !e_addr && e_en);
        exp_serr = !(e_cond &&  e_addr && e_en);
        lt = (e_cond && !e_en) ? "R8" : (e_addr ? "R7" : "R6");
        if (e_drvbad) lt = "R9";
        chk(lt, perr_n_o, exp_perr, "perr_n_o");
        chk(lt, serr_n_o, exp_serr, "serr_n_o");
        chk(e_drvbad ? "R9" : (e_cond ? "R4" : "R5"), parity_err_o, exp_stat, "parity_err_o");
        // apply inputs
        drive_i = drv; addr_vld_i = av; data_vld_i = dv;
        ad_i = ad; cbe_i = cbe; resp_en_i = en; stat_clr_i = clr;
        par_i = even_par(p_bits) ^ bad;
        // model the coming edge
        cond     = p_vld && !p_drv && bad;
        e_drvbad = p_vld && p_drv && bad;
        e_cond = cond; e_addr = p_addr; e_en = en;
        if (cond) exp_stat = 1;
        else if (clr) exp_stat = 0;
        p_vld = av || dv; p_drv = drv; p_addr = av; p_bits = {cbe, ad};
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, '0, '0, 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", par_oe_o, 1'b0, "par_oe_o");
        chk("R1", perr_n_o, 1'b1, "perr_n_o");
        chk("R1", serr_n_o, 1'b1, "serr_n_o");
        chk("R1", parity_err_o, 1'b0, "parity_err_o");
        rst_n = 1'b1;
        // R2: driven phases, corner patterns incl. byte-enable lines alone
        step(1, 1, 0, 32'h0, 4'h0, 0, 1, 0);
        step(1, 0, 1, 32'hFFFF_FFFF, 4'hF, 0, 1, 0);
        step(1, 0, 1, 32'h0, 4'h8, 0, 1, 0);
        step(1, 0, 1, 32'h8000_0000, 4'h0, 0, 1, 0);
        idle(2);
        // R9: driven phase with wrong PAR seen on the bus
        step(1, 0, 1, 32'h1234_5678, 4'h3, 0, 1, 0);
        step(0, 0, 0, '0, '0, 1, 1, 0);
        idle(2);
        // R6: received data phase with bad parity, enable on
        step(0, 0, 1, 32'hDEAD_BEEF, 4'h5, 0, 1, 0);
        step(0, 0, 0, '0, '0, 1, 1, 0);
        idle(2);
        // R5: clear the status
        step(0, 0, 0, '0, '0, 0, 1, 1);
        idle(2);
        // R7: received address phase with bad parity
        step(0, 1, 0, 32'h0000_0001, 4'hA, 0, 1, 0);
        step(0, 0, 0, '0, '0, 1, 1, 0);
        idle(2);
        // R5: clear in the same cycle as a new error; error wins
        step(0, 0, 1, 32'hCAFE_0000, 4'h1, 0, 1, 0);
        step(0, 0, 0, '0, '0, 1, 1, 1);
        idle(2);
        step(0, 0, 0, '0, '0, 0, 0, 1);
        // R8: enable off, status still set (R4)
        step(0, 0, 1, 32'h0F0F_0F0F, 4'h6, 0, 0, 0);
        step(0, 0, 0, '0, '0, 1, 0, 0);
        step(0, 1, 0, 32'hF0F0_0000, 4'h2, 0, 0, 0);
        step(0, 0, 0, '0, '0, 1, 0, 0);
        idle(2);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            bit av, dv;
            av = ($urandom_range(0, 3) == 0);
            dv = !av && ($urandom_range(0, 2) != 0);
            step($urandom_range(0, 1), av, dv, $urandom, 4'($urandom),
                 ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) != 0),
                 ($urandom_range(0, 7) == 0));
        end
        idle(3);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule